// File: doc/BRIEF.md
# Dual-Use Serial Programming Port

This block lets four package pins serve two purposes. An active-low programming-enable input picks the purpose. While programming is off, all four pins are handed to the core logic as ordinary dedicated inputs, and the readback pin's output driver is switched off.

While programming is on, the four pins form a serial port:
- a data pin, which supplies serial data and also steers the control state machine;
- a control pin, which tells the state machine whether to advance or stay;
- a shift clock;
- a readback pin, which drives out the most significant bit of a shift register.

The state machine has three states: idle, shift and execute. It moves on a rising shift-clock edge only when the control pin is high, and the data-pin level picks the branch. With the control pin low, the state machine holds its state. If it is in the shift state, that edge shifts the data-pin level into the register, most significant bit first.

Integrators connect the parallel word and the state to the programming engine behind the port. The non-volatile array and the command decoding are not part of this block. Turning programming off sends the state machine back to idle at once, with no clock edge needed. The shift register keeps its contents, so a word loaded before that moment can still be used afterwards.

Top module: `dual_pin_prog_port`

## Requirements
- R1: While `prg_en_n` is high, `logic_in[0]` follows `pin_dat`, `logic_in[1]` follows `pin_ctl`, `logic_in[2]` follows `pin_rbk_i` and `logic_in[3]` follows `pin_shk`, all without delay, and `pin_rbk_oe` is 0.
- R2: While `prg_en_n` is low, `logic_in` reads all zeros and `pin_rbk_oe` is 1.
- R3: While `rst_n` is low, the block is held in its reset state, and it enters that state asynchronously: `prg_state` is 0 (idle), `prg_word` is zero and `pin_rbk_o` is 0.
- R4: The states are encoded as idle = 0, shift = 1 and execute = 2. On a rising `pin_shk` edge with `pin_ctl` = 1, the next state is as follows:
  - from idle: shift if `pin_dat` = 1, otherwise idle;
  - from shift: execute if `pin_dat` = 1, otherwise idle;
  - from execute: shift if `pin_dat` = 1, otherwise idle.
- R5: A rising `pin_shk` edge with `pin_ctl` = 0 leaves `prg_state` unchanged.
- R6: In the shift state, a rising edge with `pin_ctl` = 0 moves `prg_word` one place toward its MSB and puts `pin_dat` into bit 0. Sixteen such edges therefore load a word whose first-sent bit ends up in bit 15.
- R7: A rising edge in the idle or execute state, or any rising edge with `pin_ctl` = 1, leaves `prg_word` unchanged.
- R8: `pin_rbk_o` takes the value of `prg_word[15]` on the falling edge of `pin_shk`. Between a rising edge and the next falling edge it keeps its previous value.
- R9: Raising `prg_en_n` forces `prg_state` to idle and `pin_rbk_o` to 0 at once, with no clock edge. `prg_word` keeps its value.
- R10: While `prg_en_n` is high, edges on `pin_shk` change neither `prg_state` nor `prg_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset of the whole port |
| prg_en_n | input | 1 | Active-low programming enable |
| pin_dat | input | 1 | Serial data and branch select; dedicated input when not programming |
| pin_ctl | input | 1 | State-advance control; dedicated input when not programming |
| pin_shk | input | 1 | Shift clock; dedicated input when not programming |
| pin_rbk_i | input | 1 | Input level of the readback pin |
| pin_rbk_o | output | 1 | Readback serial data driven onto the pin |
| pin_rbk_oe | output | 1 | Output enable of the readback pin driver |
| logic_in | output | 4 | Dedicated inputs handed to the core logic |
| prg_state | output | 2 | Current programming state (0 idle, 1 shift, 2 execute) |
| prg_word | output | 16 | Parallel contents of the shift register |

## Verification
The bench checks that `pin_rbk_o` keeps its old MSB through the high phase after a shift and only changes after the falling edge. A design that sampled readback on the rising edge would show the new bit half a cycle early.

It raises the enable in the middle of a shift and looks for idle before any edge. A synchronous return would leave the state at shift. It also checks that the loaded word survives, since a design that cleared the register on disable would lose it.

Other runs look for wrong shifting in the wrong states:
- a control-low edge in the idle or execute state, which must not shift;
- toggling the shift clock while programming is off, which must not shift.

A wrong branch table shows up in the vector walk as a state mismatch.

// File: rtl/dpp_pkg.sv
package dpp_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_EXEC  = 2'd2
  } dpp_state_e;

  // Next-state rule: control low holds, control high branches on data level.
  function automatic dpp_state_e dpp_next(dpp_state_e cur, logic ctl, logic dat);
    dpp_state_e nxt;
    case (cur)
      ST_IDLE:  nxt = dat ? ST_SHIFT : ST_IDLE;
      ST_SHIFT: nxt = dat ? ST_EXEC  : ST_IDLE;
      ST_EXEC:  nxt = dat ? ST_SHIFT : ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    if (!ctl) nxt = cur;
    return nxt;
  endfunction

endpackage

// File: rtl/dpp_pin_mux.sv
module dpp_pin_mux #(
  parameter int N = 4
) (
  input  logic         prg_en_n,
  input  logic [N-1:0] pins,
  output logic [N-1:0] logic_in,
  output logic         rbk_oe,
  output logic         prog_on
);

  assign prog_on = ~prg_en_n;
  assign rbk_oe  = prog_on;

  // Each shared pin is released to the core only in its logic-input role.
  generate
    for (genvar g = 0; g < N; g++) begin : g_pin
      assign logic_in[g] = pins[g] & prg_en_n;
    end
  endgenerate

endmodule

// File: rtl/dpp_fsm.sv
module dpp_fsm
  import dpp_pkg::*;
(
  input  logic       shk,
  input  logic       arst_n,
  input  logic       ctl,
  input  logic       dat,
  output dpp_state_e state,
  output logic       shift_fire
);

  always_ff @(posedge shk or negedge arst_n) begin
    if (!arst_n) state <= ST_IDLE;
    else         state <= dpp_next(state, ctl, dat);
  end

  // A held edge in the shift state is the only event that moves data.
  assign shift_fire = (state == ST_SHIFT) && !ctl;

endmodule

// File: rtl/dpp_shift.sv
module dpp_shift #(
  parameter int W = 16
) (
  input  logic         shk,
  input  logic         rst_n,
  input  logic         arst_n,
  input  logic         fire,
  input  logic         dat,
  output logic [W-1:0] word,
  output logic         rbk
);

  function automatic logic [W-1:0] shift_in(logic [W-1:0] cur, logic b);
    return {cur[W-2:0], b};
  endfunction

  // Contents survive a programming disable; only the port reset clears them.
  always_ff @(posedge shk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (fire) word <= shift_in(word, dat);
  end

  // Readback launches on the opposite edge so the receiver gets a half period.
  always_ff @(negedge shk or negedge arst_n) begin
    if (!arst_n) rbk <= 1'b0;
    else         rbk <= word[W-1];
  end

endmodule

// File: rtl/dual_pin_prog_port.sv
module dual_pin_prog_port
  import dpp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         rst_n,
  input  logic         prg_en_n,
  input  logic         pin_dat,
  input  logic         pin_ctl,
  input  logic         pin_shk,
  input  logic         pin_rbk_i,
  output logic         pin_rbk_o,
  output logic         pin_rbk_oe,
  output logic [3:0]   logic_in,
  output logic [1:0]   prg_state,
  output logic [W-1:0] prg_word
);

  localparam int NPIN = 4;

  logic [NPIN-1:0] pin_vec;
  logic            prog_on;
  logic            arst_n;
  logic            shift_fire;
  dpp_state_e      fsm_state;

  assign pin_vec = {pin_shk, pin_rbk_i, pin_ctl, pin_dat};

  dpp_pin_mux #(.N(NPIN)) u_mux (
    .prg_en_n (prg_en_n),
    .pins     (pin_vec),
    .logic_in (logic_in),
    .rbk_oe   (pin_rbk_oe),
    .prog_on  (prog_on)
  );

  // Leaving programming mode acts as an immediate return to idle.
  assign arst_n = rst_n & prog_on;

  dpp_fsm u_fsm (
    .shk        (pin_shk),
    .arst_n     (arst_n),
    .ctl        (pin_ctl),
    .dat        (pin_dat),
    .state      (fsm_state),
    .shift_fire (shift_fire)
  );

  dpp_shift #(.W(W)) u_shift (
    .shk    (pin_shk),
    .rst_n  (rst_n),
    .arst_n (arst_n),
    .fire   (shift_fire),
    .dat    (pin_dat),
    .word   (prg_word),
    .rbk    (pin_rbk_o)
  );

  assign prg_state = fsm_state;

endmodule

// File: rtl/dual_pin_prog_port_chk.sv
module dual_pin_prog_port_chk #(
  parameter int W = 16
) (
  input logic         rst_n,
  input logic         prg_en_n,
  input logic         pin_dat,
  input logic         pin_ctl,
  input logic         pin_shk,
  input logic         pin_rbk_o,
  input logic         pin_rbk_oe,
  input logic [3:0]   logic_in,
  input logic [1:0]   prg_state,
  input logic [W-1:0] prg_word,
  input logic         shift_fire
);

  localparam logic [1:0] S_IDLE  = 2'd0;
  localparam logic [1:0] S_SHIFT = 2'd1;
  localparam logic [1:0] S_EXEC  = 2'd2;

  a_r5_hold_on_ctl_low: assert property (@(posedge pin_shk) disable iff (!rst_n || prg_en_n)
    !pin_ctl |=> $stable(prg_state));

  a_r4_no_exec_from_idle: assert property (@(posedge pin_shk) disable iff (!rst_n || prg_en_n)
    (prg_state == S_IDLE) |=> (prg_state != S_EXEC));

  a_r4_shift_to_exec: assert property (@(posedge pin_shk) disable iff (!rst_n || prg_en_n)
    (prg_state == S_SHIFT && pin_ctl && pin_dat) |=> (prg_state == S_EXEC));

  a_r6_shift_msb_first: assert property (@(posedge pin_shk) disable iff (!rst_n || prg_en_n)
    shift_fire |=> (prg_word == {$past(prg_word[W-2:0]), $past(pin_dat)}));

  a_r7_word_stable: assert property (@(posedge pin_shk) disable iff (!rst_n || prg_en_n)
    !shift_fire |=> $stable(prg_word));

  a_r8_rbk_on_fall: assert property (@(negedge pin_shk) disable iff (!rst_n || prg_en_n)
    1'b1 |=> (pin_rbk_o == $past(prg_word[W-1])));

  a_r9_idle_when_off: assert property (@(posedge pin_shk) disable iff (!rst_n)
    prg_en_n |-> (prg_state == S_IDLE && !pin_rbk_o && !pin_rbk_oe));

  a_r2_core_quiet: assert property (@(posedge pin_shk) disable iff (!rst_n)
    !prg_en_n |-> (logic_in == 4'b0000 && pin_rbk_oe));

endmodule

bind dual_pin_prog_port dual_pin_prog_port_chk #(.W(W)) u_chk (
  .rst_n      (rst_n),
  .prg_en_n   (prg_en_n),
  .pin_dat    (pin_dat),
  .pin_ctl    (pin_ctl),
  .pin_shk    (pin_shk),
  .pin_rbk_o  (pin_rbk_o),
  .pin_rbk_oe (pin_rbk_oe),
  .logic_in   (logic_in),
  .prg_state  (prg_state),
  .prg_word   (prg_word),
  .shift_fire (shift_fire)
);

// File: tb/tb_dual_pin_prog_port.sv
module tb_dual_pin_prog_port;

  localparam int W  = 16;
  localparam int NV = 12;
  // {ctl, dat, expected state, expected word}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 1'b1, 2'd0, 16'h0000},
    {1'b1, 1'b0, 2'd0, 16'h0000},
    {1'b1, 1'b1, 2'd1, 16'h0000},
    {1'b0, 1'b1, 2'd1, 16'h0001},
    {1'b0, 1'b0, 2'd1, 16'h0002},
    {1'b1, 1'b1, 2'd2, 16'h0002},
    {1'b0, 1'b1, 2'd2, 16'h0002},
    {1'b1, 1'b1, 2'd1, 16'h0002},
    {1'b0, 1'b1, 2'd1, 16'h0005},
    {1'b1, 1'b0, 2'd0, 16'h0005},
    {1'b1, 1'b1, 2'd1, 16'h0005},
    {1'b1, 1'b0, 2'd0, 16'h0005}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rst_n, prg_en_n, pin_dat, pin_ctl, pin_rbk_i;
  logic         pin_rbk_o, pin_rbk_oe;
  logic [3:0]   logic_in;
  logic [1:0]   prg_state;
  logic [W-1:0] prg_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  dual_pin_prog_port #(.W(W)) dut (
    .rst_n(rst_n), .prg_en_n(prg_en_n), .pin_dat(pin_dat), .pin_ctl(pin_ctl),
    .pin_shk(clk), .pin_rbk_i(pin_rbk_i), .pin_rbk_o(pin_rbk_o),
    .pin_rbk_oe(pin_rbk_oe), .logic_in(logic_in), .prg_state(prg_state),
    .prg_word(prg_word)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called in the low phase; applies inputs, takes one rising and falling edge.
  task automatic step(input logic ctl, input logic dat);
    pin_ctl = ctl;
    pin_dat = dat;
    @(posedge clk);
    #6;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] pat;
    rst_n = 1'b0; prg_en_n = 1'b1; pin_dat = 1'b1; pin_ctl = 1'b0; pin_rbk_i = 1'b1;
    repeat (2) @(posedge clk);
    #6;
    chk("R3 state", 32'(prg_state), 32'd0);
    chk("R3 word", 32'(prg_word), 32'd0);
    chk("R3 rbk", 32'(pin_rbk_o), 32'd0);
    chk("R1 pass low phase", 32'(logic_in), 32'b0101);
    chk("R1 oe off", 32'(pin_rbk_oe), 32'd0);
    rst_n = 1'b1;

    // R10: clocks while programming is off touch nothing
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R10 state", 32'(prg_state), 32'd0);
    chk("R10 word", 32'(prg_word), 32'd0);
    pin_ctl = 1'b1; pin_dat = 1'b0; pin_rbk_i = 1'b0;
    @(posedge clk);
    #2;
    chk("R1 pass high phase", 32'(logic_in), 32'b1010);
    #4;

    // R2
    prg_en_n = 1'b0;
    pin_rbk_i = 1'b1;
    #1;
    chk("R2 inputs zero", 32'(logic_in), 32'd0);
    chk("R2 oe on", 32'(pin_rbk_oe), 32'd1);

    // R4 R5 R7 table walk
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][19], VEC[i][18]);
      chk("R4/R5 state", 32'(prg_state), 32'(VEC[i][17:16]));
      chk("R6/R7 word", 32'(prg_word), 32'(VEC[i][15:0]));
      chk("R8 rbk", 32'(pin_rbk_o), 32'(VEC[i][15]));
    end

    // R6 full word MSB first
    step(1'b1, 1'b1);
    pat = 16'hA5C3;
    for (int b = W - 1; b >= 0; b--) step(1'b0, pat[b]);
    chk("R6 word", 32'(prg_word), 32'h0000A5C3);
    chk("R6 state", 32'(prg_state), 32'd1);
    chk("R8 rbk msb", 32'(pin_rbk_o), 32'd1);

    // R8 readback holds through the high phase
    pin_ctl = 1'b0; pin_dat = 1'b1;
    @(posedge clk);
    #2;
    chk("R6 extra shift", 32'(prg_word), 32'h00004B87);
    chk("R8 rbk held", 32'(pin_rbk_o), 32'd1);
    #4;
    chk("R8 rbk after fall", 32'(pin_rbk_o), 32'd0);

    // R9 immediate idle on disable
    prg_en_n = 1'b1;
    #1;
    chk("R9 state", 32'(prg_state), 32'd0);
    chk("R9 word kept", 32'(prg_word), 32'h00004B87);
    chk("R9 oe", 32'(pin_rbk_oe), 32'd0);
    #1;
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    chk("R10 state off", 32'(prg_state), 32'd0);
    chk("R10 word off", 32'(prg_word), 32'h00004B87);

    // re-enable starts from idle
    prg_en_n = 1'b0;
    #1;
    step(1'b1, 1'b1);
    chk("R4 reentry shift", 32'(prg_state), 32'd1);
    step(1'b1, 1'b1);
    chk("R4 exec", 32'(prg_state), 32'd2);

    // R3 asynchronous reset mid-run
    rst_n = 1'b0;
    #1;
    chk("R3 async state", 32'(prg_state), 32'd0);
    chk("R3 async word", 32'(prg_word), 32'd0);
    chk("R3 async rbk", 32'(pin_rbk_o), 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule